// File: doc/BRIEF.md
# Cross-Product FM Discriminator

This block turns a stream of decimated baseband I/Q samples into FM-demodulated samples. Each time a new sample pair arrives with its valid strobe, the block forms the two-dimensional cross product between the stored preceding vector and the new one. That product is `cur_i * prev_q - prev_i * cur_q`. For small phase steps, the result is proportional to the rotation between the two vectors, which is the instantaneous frequency. No absolute phase is ever computed, so the block needs no arctangent and no differentiator.

The datapath has two pipeline stages. The first stage holds the two products and updates the stored vector. The second stage subtracts the products, applies an arithmetic right shift chosen at run time, and clips the result to the output width. Each input sample produces exactly one output sample, with its own strobe. The output feeds an audio modulator further down the chain.

Top module: `fm_xprod_disc`

## Requirements
- R1: For each accepted sample, `disc_out` equals `clip((cur_i*prev_q - prev_i*cur_q) >>> scale_sh)`. Here (prev_i, prev_q) is the sample accepted before it. Example: a previous sample of (1,0) followed by a current sample of (0,1) gives -1.
- R2: The stored previous vector is zero after reset. The first sample accepted after reset therefore yields 0.
- R3: The stored previous vector changes only on a cycle where `smp_valid` is high. Samples presented while `smp_valid` is low do not affect any later result.
- R4: `disc_valid` goes high exactly two clock edges after a sample is accepted, for one cycle per sample. Back-to-back samples are supported, and no output pulse appears for cycles without a valid input.
- R5: The difference is shifted right arithmetically by `scale_sh` (0 to 2^SHW-1) before clipping. Bits shifted out are dropped, which rounds toward minus infinity (-3 shifted by 1 gives -2).
- R6: The shifted value saturates to the signed OW-bit range. With the default OW=16, that range runs from -32768 to +32767.
- R7: `disc_out` keeps its last value while `disc_valid` is low.
- R8: While reset is high and after it is released, `disc_valid` is 0 and `disc_out` is 0 until the first output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe for `smp_i`/`smp_q` |
| smp_i | input | DW | In-phase sample, signed two's complement |
| smp_q | input | DW | Quadrature sample, signed two's complement |
| scale_sh | input | SHW | Arithmetic right-shift amount applied to the difference |
| disc_valid | output | 1 | Output strobe |
| disc_out | output | OW | Demodulated sample, signed, saturated |

## Verification
Two things can happen on the same clock edge. One is a new sample loading the product stage and replacing the stored vector. The other is the preceding sample's difference being shifted, clipped and registered at the output. The bench provokes this overlap by streaming samples on consecutive cycles, with idle gaps mixed in, across three shift settings. It judges every output against a bench-side model that tracks its own previous vector and counts only strobed samples. On each idle slot the bench also checks that no strobe appears and that the output value is held.

// File: rtl/fm_xprod_pkg.sv
package fm_xprod_pkg;

  // Result of the clip decision in the scaling stage.
  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HI   = 2'd1,
    CLIP_LO   = 2'd2
  } clip_e;

endpackage

// File: rtl/xp_prev_hold.sv
module xp_prev_hold #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld,
  input  logic signed [DW-1:0] cur_i,
  input  logic signed [DW-1:0] cur_q,
  output logic signed [DW-1:0] prev_i,
  output logic signed [DW-1:0] prev_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_i <= '0;
      prev_q <= '0;
    end else if (ld) begin
      prev_i <= cur_i;
      prev_q <= cur_q;
    end
  end

  // R3: stored vector must not move without a strobe
  p_prev_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(prev_i) && $stable(prev_q)));

  // R3: a strobed sample becomes the stored vector
  p_prev_load_r3: assert property (@(posedge clk) disable iff (rst)
    ld |=> (prev_i == $past(cur_i) && prev_q == $past(cur_q)));

endmodule

// File: rtl/xp_cross_mul.sv
module xp_cross_mul #(
  parameter int DW = 12,
  localparam int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] cur_i,
  input  logic signed [DW-1:0] cur_q,
  input  logic signed [DW-1:0] prev_i,
  input  logic signed [DW-1:0] prev_q,
  output logic signed [PW-1:0] prod_a,
  output logic signed [PW-1:0] prod_b,
  output logic                 vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_a <= '0;
      prod_b <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= en;
      if (en) begin
        prod_a <= cur_i * prev_q;
        prod_b <= prev_i * cur_q;
      end
    end
  end

  // R4: first pipeline stage follows the input strobe by one edge
  p_stage1_lat_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> vld);

  p_stage1_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !vld);

endmodule

// File: rtl/xp_scale_sat.sv
module xp_scale_sat
  import fm_xprod_pkg::*;
#(
  parameter int PW  = 24,
  parameter int OW  = 16,
  parameter int SHW = 4,
  localparam int DFW = PW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [PW-1:0]  prod_a,
  input  logic signed [PW-1:0]  prod_b,
  input  logic        [SHW-1:0] shamt,
  output logic                  out_vld,
  output logic signed [OW-1:0]  out_val
);

  logic signed [DFW-1:0] diff;
  logic signed [DFW-1:0] shifted;
  logic signed [OW-1:0]  clipped;
  clip_e                 clip_st;

  always_comb begin
    diff    = DFW'(prod_a) - DFW'(prod_b);
    shifted = diff >>> shamt;
  end

  generate
    if (OW >= DFW) begin : g_wide
      // Output wide enough for any difference: no clipping needed.
      always_comb begin
        clip_st = CLIP_NONE;
        clipped = OW'(shifted);
      end
    end else begin : g_clip
      localparam logic signed [DFW-1:0] MAXV = DFW'((longint'(1) <<< (OW - 1)) - 1);
      localparam logic signed [DFW-1:0] MINV = DFW'(-(longint'(1) <<< (OW - 1)));
      always_comb begin
        if (shifted > MAXV)      clip_st = CLIP_HI;
        else if (shifted < MINV) clip_st = CLIP_LO;
        else                     clip_st = CLIP_NONE;
        case (clip_st)
          CLIP_HI: clipped = {1'b0, {(OW-1){1'b1}}};
          CLIP_LO: clipped = {1'b1, {(OW-1){1'b0}}};
          default: clipped = shifted[OW-1:0];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_val <= '0;
    end else begin
      out_vld <= en;
      if (en) out_val <= clipped;
    end
  end

  // R4: output strobe follows stage-one strobe by one edge
  p_out_lat_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> out_vld);

  p_out_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_vld);

  // R7: result held between strobes
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_val));

endmodule

// File: rtl/fm_xprod_disc.sv
module fm_xprod_disc #(
  parameter int DW  = 12,
  parameter int OW  = 16,
  parameter int SHW = 4,
  localparam int PW = 2 * DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_valid,
  input  logic signed [DW-1:0]  smp_i,
  input  logic signed [DW-1:0]  smp_q,
  input  logic        [SHW-1:0] scale_sh,
  output logic                  disc_valid,
  output logic signed [OW-1:0]  disc_out
);

  logic signed [DW-1:0] prev_i;
  logic signed [DW-1:0] prev_q;
  logic signed [PW-1:0] prod_a;
  logic signed [PW-1:0] prod_b;
  logic                 s1_vld;

  xp_prev_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .ld     (smp_valid),
    .cur_i  (smp_i),
    .cur_q  (smp_q),
    .prev_i (prev_i),
    .prev_q (prev_q)
  );

  xp_cross_mul #(.DW(DW)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .en     (smp_valid),
    .cur_i  (smp_i),
    .cur_q  (smp_q),
    .prev_i (prev_i),
    .prev_q (prev_q),
    .prod_a (prod_a),
    .prod_b (prod_b),
    .vld    (s1_vld)
  );

  xp_scale_sat #(.PW(PW), .OW(OW), .SHW(SHW)) u_scale (
    .clk     (clk),
    .rst     (rst),
    .en      (s1_vld),
    .prod_a  (prod_a),
    .prod_b  (prod_b),
    .shamt   (scale_sh),
    .out_vld (disc_valid),
    .out_val (disc_out)
  );

  // R2: the first sample after reset sees a zero stored vector, so both products are zero
  p_first_zero_r2: assert property (@(posedge clk)
    ($past(rst) && !rst && smp_valid) |=> (prod_a == '0 && prod_b == '0));

endmodule

// File: tb/sim_fm_xprod_disc.sv
module sim_fm_xprod_disc;

  localparam int DW  = 12;
  localparam int OW  = 16;
  localparam int SHW = 4;
  localparam int NV  = 16;

  localparam int TI[NV] = '{100, 0, -100, 0, 0, 2047, -2048, -2048, 5, 300, -301, 1, -1, 2047, 0, 0};
  localparam int TQ[NV] = '{0, 100, 0, 0, -100, -2048, 2047, -2048, 7, -45, 44, 1, 2, 2047, 0, 0};
  localparam bit TV[NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 0, 0};

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  smp_valid = 1'b0;
  logic signed [DW-1:0]  smp_i = '0;
  logic signed [DW-1:0]  smp_q = '0;
  logic        [SHW-1:0] scale_sh = '0;
  logic                  disc_valid;
  logic signed [OW-1:0]  disc_out;

  int n_chk  = 0;
  int n_fail = 0;
  longint m_pi = 0, m_pq = 0;
  longint last_out = 0;
  bit     fresh = 1'b1;

  always #4 clk = ~clk;

  fm_xprod_disc #(.DW(DW), .OW(OW), .SHW(SHW)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .scale_sh(scale_sh), .disc_valid(disc_valid), .disc_out(disc_out)
  );

  function automatic longint model(longint ci, longint cq, longint pi, longint pq, int sh);
    longint d;
    longint lim;
    d   = (ci * pq - pi * cq) >>> sh;
    lim = longint'(1) <<< (OW - 1);
    if (d > lim - 1) d = lim - 1;
    if (d < -lim)    d = -lim;
    return d;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 valid in reset", longint'(disc_valid), 0);
    check("R8 out in reset", longint'(disc_out), 0);
    rst = 1'b0;
    m_pi = 0; m_pq = 0; last_out = 0; fresh = 1'b1;
    @(negedge clk);
    check("R8 valid after reset", longint'(disc_valid), 0);
    check("R8 out after reset", longint'(disc_out), 0);
  endtask

  // Walks the table with a fixed shift; output of entry n is checked two negedges later.
  task automatic run_table(int sh);
    longint exp_v[NV];
    bit     first_v[NV];
    scale_sh = SHW'(sh);
    for (int n = 0; n < NV + 2; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        if (TV[n-2]) begin
          check("R4 strobe", longint'(disc_valid), 1);
          if (first_v[n-2])            check("R2 first after reset", longint'(disc_out), exp_v[n-2]);
          else if (exp_v[n-2] ==  32767 || exp_v[n-2] == -32768)
                                       check("R6 clip", longint'(disc_out), exp_v[n-2]);
          else if (sh != 0)            check("R5 shift", longint'(disc_out), exp_v[n-2]);
          else                         check("R1 cross", longint'(disc_out), exp_v[n-2]);
          last_out = longint'(disc_out);
        end else begin
          check("R4 no strobe", longint'(disc_valid), 0);
          check("R7 hold", longint'(disc_out), last_out);
        end
      end
      if (n < NV) begin
        smp_valid = TV[n];
        smp_i = DW'(TI[n]);
        smp_q = DW'(TQ[n]);
        first_v[n] = 1'b0;
        if (TV[n]) begin
          // R3: model vector only advances on strobed samples
          exp_v[n]   = model(TI[n], TQ[n], m_pi, m_pq, sh);
          first_v[n] = fresh;
          fresh = 1'b0;
          m_pi = TI[n]; m_pq = TQ[n];
        end
      end else begin
        smp_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    run_table(0);
    run_table(5);   // no reset: stored vector carries over
    do_reset();
    run_table(12);

    // R5: rounding toward minus infinity, -3 >>> 1 = -2
    do_reset();
    scale_sh = SHW'(1);
    @(negedge clk); smp_valid = 1'b1; smp_i = DW'(3); smp_q = DW'(0);
    @(negedge clk); smp_i = DW'(0); smp_q = DW'(1);   // 0*0 - 3*1 = -3
    @(negedge clk); smp_valid = 1'b0;
    check("R2 first after reset", longint'(disc_out), 0);
    @(negedge clk);
    check("R5 floor shift", longint'(disc_out), -2);

    // R1 sign convention: (1,0) then (0,1) gives -1
    do_reset();
    scale_sh = '0;
    @(negedge clk); smp_valid = 1'b1; smp_i = DW'(1); smp_q = DW'(0);
    @(negedge clk); smp_i = DW'(0); smp_q = DW'(1);
    @(negedge clk); smp_valid = 1'b0; smp_i = DW'(-2000); smp_q = DW'(900);
    @(negedge clk);
    check("R1 sign", longint'(disc_out), -1);
    // R3: ignored inputs above must not alter next result: (1,1) after (0,1) -> 1*1 - 0*1 = 1
    repeat (3) @(negedge clk);
    check("R7 idle hold", longint'(disc_out), -1);
    smp_valid = 1'b1; smp_i = DW'(1); smp_q = DW'(1);
    @(negedge clk); smp_valid = 1'b0;
    check("R4 latency one edge", longint'(disc_valid), 0);
    @(negedge clk);
    check("R4 latency two edges", longint'(disc_valid), 1);
    check("R3 ignored samples", longint'(disc_out), 1);

    report();
  end

endmodule